// File: doc/BRIEF.md
# Tuner Control Register Interface over I2C

This block is a two-wire serial slave that holds the tuning word and the control settings of a frequency synthesiser, and reports one status byte to the bus master. It runs from a system clock at least eight times faster than SCL. Both bus lines are resynchronised, START and STOP are found as SDA edges while SCL is high, and the block pulls SDA low to acknowledge.

The slave answers one of four addresses, picked by a two-bit select input. In a write, the leading bit of each byte pair steers it. A leading 0 opens a divider pair: seven high bits of the 15-bit ratio, then the eight low bits. A leading 1 opens a control pair: a control byte, then a byte of port enables. Pairs may follow one another inside one transaction. Each byte reaches its output latch only once all eight of its bits have arrived.

In a read, the slave sends a status byte. It holds a power-on flag, the lock flag, three port levels and a 3-bit level code. It resends the byte for as long as the master acknowledges. The power-on flag is set by reset and is cleared only when a read transaction is closed by a STOP.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave acknowledges an address byte only when its seven upper bits equal 1,1,0,0,0 followed by the select input (select bit 1, then bit 0). A non-matching address is not acknowledged, and the data bytes that follow it change no output.
- R2: The slave changes its SDA pull only while SCL is low. Its acknowledge stays steady for the whole SCL high time.
- R3: A write byte whose MSB is 0 loads its bits 6..0 into ratio bits 14..8. The next byte loads ratio bits 7..0.
- R4: A write byte whose MSB is 1 is a control byte: bit 6 sets high pump current, bit 5 sets test routing, bit 4 disables the pump and bit 0 disables the drive output. The next byte sets the port enables, with bit n driving port n (1 = on).
- R5: Several byte pairs of either kind can follow one address, up to the STOP. Each byte is acknowledged.
- R6: A byte cut off by START or STOP before its eighth bit changes no output. Bytes completed earlier in that transaction keep their effect.
- R7: After reset the ratio, the control bits and the port enables are all 0, SDA is released and the power-on flag is 1.
- R8: The status byte, MSB first, is: power-on flag, lock, level of port 7, port 5, port 4, then a 3-bit level code. The level code equals the number of asserted level comparators (0 to 4, so 100 for the top band).
- R9: In a read, a master acknowledge makes the slave send a fresh copy of the status byte. A master no-acknowledge makes it release SDA.
- R10: The power-on flag is cleared by a STOP that ends a read transaction. A STOP after a write does not clear it, and neither does a repeated START after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up or supply dropout) |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Selects one of the four slave addresses |
| lock_i | input | 1 | Loop lock flag |
| pin_lvl_i | input | 3 | Levels of ports 7, 5, 4 (bit 2 = port 7) |
| lvl_cmp_i | input | 4 | Level comparator outputs |
| div_ratio_o | output | 15 | Programmed divide ratio |
| cp_hi_o | output | 1 | High pump current select |
| test_route_o | output | 1 | Test routing enable |
| pump_off_o | output | 1 | Charge pump disable |
| drive_off_o | output | 1 | Drive output disable |
| port_on_o | output | 8 | Port enables, 1 = low impedance |

## Verification
A table of byte pairs is written under each of the four addresses. The pairs mix divider pairs and control pairs, use all-ones and all-zeros values, and set control bytes whose filler bits vary. This shows that routing depends only on the leading bit and that the select input moves the address. Directed sequences then send a wrong address, chain three pairs in one transaction, and cut bytes short both in the lead byte and in the second byte of a pair. Reads run with different lock, pin and comparator patterns, and with master acknowledge and no-acknowledge. They are closed both by STOP and by a repeated START, which isolates the rule for clearing the power-on flag.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int DIV_W    = 15;
  localparam int DIV_HI_W = DIV_W - 8;
  localparam int CMP_N    = 4;
  localparam int CODE_W   = 3;
  localparam int PIN_N    = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } eng_state_e;

  typedef struct packed {
    logic cp_hi;
    logic test_route;
    logic pump_off;
    logic drive_off;
  } ctrl_t;

  // number of asserted comparators, binary
  function automatic logic [CODE_W-1:0] level_code(input logic [CMP_N-1:0] cmp);
    logic [CODE_W-1:0] n;
    n = '0;
    for (int i = 0; i < CMP_N; i++) n = n + CODE_W'(cmp[i]);
    return n;
  endfunction

  function automatic logic [7:0] status_byte(input logic por, input logic lock,
                                             input logic [PIN_N-1:0] pins,
                                             input logic [CMP_N-1:0] cmp);
    return {por, lock, pins, level_code(cmp)};
  endfunction

  function automatic logic addr_match(input logic [7:0] b, input logic [1:0] sel,
                                      input logic [4:0] fixed);
    return b[7:1] == {fixed, sel};
  endfunction
endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status,
  output logic       sda_pull,
  output logic       wr_commit,
  output logic [7:0] wr_byte,
  output logic       addr_hit,
  output logic       rd_txn
);
  eng_state_e state;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      shreg     <= '0;
      cnt       <= '0;
      sda_pull  <= 1'b0;
      mack      <= 1'b0;
      rd_txn    <= 1'b0;
      wr_commit <= 1'b0;
      addr_hit  <= 1'b0;
    end else begin
      wr_commit <= 1'b0;
      addr_hit  <= 1'b0;
      if (start_evt) begin
        state    <= S_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
        rd_txn   <= 1'b0;
      end else if (stop_evt) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
        rd_txn   <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == S_WDAT) begin
                sda_pull  <= 1'b1;
                wr_commit <= 1'b1;
                state     <= S_WACK;
              end else if (addr_match(shreg, addr_sel, ADDR_FIXED)) begin
                sda_pull <= 1'b1;
                addr_hit <= 1'b1;
                rd_txn   <= shreg[0];
                state    <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rd_txn) begin
              shreg    <= status;
              sda_pull <= ~status[7];
              state    <= S_RDAT;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_WDAT;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            state    <= S_WDAT;
          end
          S_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_pull <= 1'b0;
              state    <= S_RACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_pull <= ~shreg[6];
              cnt      <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                shreg    <= status;
                sda_pull <= ~status[7];
                cnt      <= '0;
                state    <= S_RDAT;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_byte = shreg;

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R2

  AST_ACK_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !start_evt && !stop_evt) |-> $stable(sda_pull)); // R2
endmodule

// File: rtl/tuner_regfile.sv
module tuner_regfile
  import tuner_i2c_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              rd_txn,
  input  logic              wr_commit,
  input  logic [7:0]        wr_byte,
  output logic [DIV_W-1:0]  div_ratio,
  output ctrl_t             ctrl,
  output logic [PORT_W-1:0] ports,
  output logic              por
);
  logic second_q, to_ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q  <= 1'b0;
      to_ctl_q  <= 1'b0;
      div_ratio <= '0;
      ctrl      <= '0;
      ports     <= '0;
      por       <= 1'b1;
    end else begin
      if (stop_evt && rd_txn) por <= 1'b0;
      if (start_evt) second_q <= 1'b0;
      else if (wr_commit) begin
        if (!second_q) begin
          second_q <= 1'b1;
          to_ctl_q <= wr_byte[7];
          if (wr_byte[7])
            ctrl <= '{cp_hi: wr_byte[6], test_route: wr_byte[5],
                      pump_off: wr_byte[4], drive_off: wr_byte[0]};
          else
            div_ratio[DIV_W-1:8] <= wr_byte[DIV_HI_W-1:0];
        end else begin
          second_q <= 1'b0;
          if (to_ctl_q) ports <= wr_byte[PORT_W-1:0];
          else          div_ratio[7:0] <= wr_byte;
        end
      end
    end
  end

  AST_DIV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(div_ratio)); // R6

  AST_PORTS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ports)); // R6
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PORT_W      = 8,
  parameter logic [4:0] ADDR_FIXED  = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [PIN_N-1:0]  pin_lvl_i,
  input  logic [CMP_N-1:0]  lvl_cmp_i,
  output logic [DIV_W-1:0]  div_ratio_o,
  output logic              cp_hi_o,
  output logic              test_route_o,
  output logic              pump_off_o,
  output logic              drive_off_o,
  output logic [PORT_W-1:0] port_on_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_commit, addr_hit, rd_txn, por;
  logic [7:0] wr_byte, status;
  ctrl_t ctrl;

  tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_evt, .stop_evt
  );

  assign status = status_byte(por, lock_i, pin_lvl_i, lvl_cmp_i);

  tuner_i2c_engine #(.ADDR_FIXED(ADDR_FIXED)) u_eng (
    .clk, .rst_n, .scl_s, .sda_s, .scl_rise, .scl_fall, .start_evt, .stop_evt,
    .addr_sel(addr_sel_i), .status, .sda_pull(sda_pull_o),
    .wr_commit, .wr_byte, .addr_hit, .rd_txn
  );

  tuner_regfile #(.PORT_W(PORT_W)) u_rf (
    .clk, .rst_n, .start_evt, .stop_evt, .rd_txn, .wr_commit, .wr_byte,
    .div_ratio(div_ratio_o), .ctrl, .ports(port_on_o), .por
  );

  assign cp_hi_o      = ctrl.cp_hi;
  assign test_route_o = ctrl.test_route;
  assign pump_off_o   = ctrl.pump_off;
  assign drive_off_o  = ctrl.drive_off;

  AST_POR_CLEARS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(stop_evt)); // R10

  AST_READ_ENDS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_txn) |-> $past(start_evt || stop_evt)); // R10

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_txn |-> !wr_commit); // R9

  AST_HIT_NOT_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> !wr_commit); // R1
endmodule

// File: tb/tuner_i2c_regs_test.sv
`timescale 1ns/1ps
module tuner_i2c_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_pull;
  logic [1:0] addr_sel = 2'd0;
  logic lock = 1'b0;
  logic [2:0] pins = 3'b000;
  logic [3:0] cmp = 4'b0000;
  logic [14:0] div;
  logic cp_hi, test_route, pump_off, drive_off;
  logic [7:0] ports;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [14:0] exp_div = '0;
  logic [3:0]  exp_ctrl = '0;
  logic [7:0]  exp_port = '0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  tuner_i2c_regs uut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_sel_i(addr_sel), .lock_i(lock), .pin_lvl_i(pins), .lvl_cmp_i(cmp),
    .div_ratio_o(div), .cp_hi_o(cp_hi), .test_route_o(test_route),
    .pump_off_o(pump_off), .drive_off_o(drive_off), .port_on_o(ports)
  );

  // entries: {select, first byte, second byte}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'h12, 8'h34}, {2'd3, 8'hD1, 8'hA5}, {2'd1, 8'h7F, 8'hFF},
    {2'd2, 8'hBE, 8'h00}, {2'd0, 8'h80, 8'h5A}, {2'd3, 8'h00, 8'h00}
  };

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wc(4); scl_m = 1'b1; wc(6); sda_m = 1'b0; wc(6); scl_m = 1'b0; wc(4);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wc(4); scl_m = 1'b1; wc(6); sda_m = 1'b1; wc(8);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wc(4); scl_m = 1'b1; wc(8); scl_m = 1'b0; wc(4);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack, output logic steady);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1'b1; wc(4); scl_m = 1'b1; wc(1); a1 = ~sda_line; wc(6); a2 = ~sda_line;
    wc(1); scl_m = 1'b0; wc(4);
    ack = a1; steady = (a1 == a2);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wc(4); scl_m = 1'b1; wc(4); d[i] = sda_line; wc(4); scl_m = 1'b0; wc(4);
    end
    sda_m = ~mack; wc(4); scl_m = 1'b1; wc(8); scl_m = 1'b0; wc(4); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rd);
    return {5'b11000, s, rd};
  endfunction

  task automatic model(input logic [7:0] a, input logic [7:0] b);
    if (a[7]) begin
      exp_ctrl = {a[6], a[5], a[4], a[0]};
      exp_port = b;
    end else exp_div = {a[6:0], b};
  endtask

  task automatic check_regs(input string req);
    check(req, div, exp_div);
    check(req, {cp_hi, test_route, pump_off, drive_off}, exp_ctrl);
    check(req, ports, exp_port);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic ack, st;
    logic [7:0] d;
    wc(5); rst_n = 1'b1; wc(5);
    // R7 reset state
    check("R7 div", div, 0);
    check("R7 ctrl", {cp_hi, test_route, pump_off, drive_off}, 0);
    check("R7 ports", ports, 0);
    check("R7 sda", sda_pull, 0);

    // table walk: R1 R3 R4 with all four addresses
    for (int v = 0; v < 6; v++) begin
      addr_sel = VEC[v][17:16];
      i2c_start();
      wbyte(addr_byte(VEC[v][17:16], 1'b0), ack, st);
      check("R1 addr ack", ack, 1);
      check("R2 ack steady", st, 1);
      wbyte(VEC[v][15:8], ack, st);
      check("R5 data ack", ack, 1);
      wbyte(VEC[v][7:0], ack, st);
      i2c_stop();
      model(VEC[v][15:8], VEC[v][7:0]);
      check_regs(VEC[v][15] ? "R4 ctrl pair" : "R3 div pair");
    end

    // R1 wrong address: no ack, no change
    addr_sel = 2'd0;
    i2c_start();
    wbyte(addr_byte(2'd1, 1'b0), ack, st);
    check("R1 wrong addr nack", ack, 0);
    wbyte(8'h15, ack, st);
    wbyte(8'h55, ack, st);
    i2c_stop();
    check_regs("R1 ignored");

    // R5 three pairs after one address
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b0), ack, st);
    wbyte(8'h05, ack, st); wbyte(8'h66, ack, st);
    wbyte(8'hC0, ack, st); wbyte(8'h0F, ack, st);
    wbyte(8'h2A, ack, st); wbyte(8'h11, ack, st);
    check("R5 last ack", ack, 1);
    i2c_stop();
    model(8'hC0, 8'h0F); model(8'h2A, 8'h11);
    check_regs("R5 chained");

    // R6 lead byte cut short by STOP
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b0), ack, st);
    wbit(1'b1); wbit(1'b1); wbit(1'b1);
    i2c_stop();
    check_regs("R6 cut lead");
    // R6 second byte cut short by repeated START
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b0), ack, st);
    wbyte(8'h01, ack, st);
    wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b0), ack, st);
    i2c_stop();
    exp_div = {7'h01, exp_div[7:0]};
    check_regs("R6 cut second");

    // R8 R9 read with POR still set after writes (R10)
    lock = 1'b1; pins = 3'b101; cmp = 4'b0111;
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b1), ack, st);
    check("R1 read addr ack", ack, 1);
    rbyte(1'b1, d);
    check("R8 status", d, 8'hEB);
    rbyte(1'b0, d);
    check("R9 repeat", d, 8'hEB);
    check("R9 released", sda_pull, 0);
    // R10 repeated START does not clear POR
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b0), ack, st);
    i2c_stop();
    cmp = 4'b1111;
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b1), ack, st);
    rbyte(1'b0, d);
    i2c_stop();
    check("R10 por kept, R8 top band", d, 8'hEC);
    // R10 cleared by previous STOP; R8 other pattern
    lock = 1'b0; pins = 3'b010; cmp = 4'b0000;
    i2c_start();
    wbyte(addr_byte(2'd0, 1'b1), ack, st);
    rbyte(1'b0, d);
    i2c_stop();
    check("R10 por cleared", d, 8'h10);
    check_regs("R9 read no write");
    finish_run();
  end
endmodule